// File: doc/BRIEF.md
# Flash Converter Thermometer Encoder

This block is the digital back end of a 4-bit flash converter. Sixteen latched comparator decisions arrive as a thermometer word. The block counts how many comparators have tripped and turns that count into a 4-bit straight-binary code. The topmost comparator serves only as an over-range detector: when all sixteen have tripped, an overflow flag rises and the code saturates at all ones. The result is captured into an output register on the clock edge that ends each sample phase. That edge is marked by a one-cycle strobe. A data-change output toggles on every capture, so downstream logic gets one marker per conversion.

Two enable inputs gate the outputs in two groups: the four code bits, and the status pair (overflow and data change). Each group is modelled as a drive-enable signal. The matching output carries a behavioural high-impedance value when its group is not driven.

Top module: `flash_code_encoder`

## Requirements
- R1: With the overflow flag at 0, the registered code equals the number of ones in `comp_i`, as an unsigned binary value with bit 0 as LSB, for 0 through 15 ones.
- R2: When all 16 bits of `comp_i` are 1, the capture sets `ovf_o` to 1 and `code_o` to 4'b1111, giving the 5-bit value 31 with overflow as MSB.
- R3: A capture of any `comp_i` with at least one 0 bit clears `ovf_o` to 0.
- R4: Bubbles (a 0 below a 1) are resolved by counting ones, not by locating the highest 1. A thermometer of k ones with one interior 1 cleared yields k-1.
- R5: The output register loads only on a rising `clk` edge where `conv_end_i` is 1. The loaded value appears after that edge. With `conv_end_i` at 0, code, overflow and data change hold.
- R6: `dchg_o` inverts on every load and only on a load.
- R7: With `chip_on_i`=1 and `data_off_i`=0, both `code_oe_o` and `stat_oe_o` are 1.
- R8: With `chip_on_i`=1 and `data_off_i`=1, `code_oe_o` is 0 (code bits high-impedance) while `stat_oe_o` stays 1.
- R9: With `chip_on_i`=0, `code_oe_o` and `stat_oe_o` are both 0 whatever `data_off_i` is.
- R10: While `rst_n` is 0, the register holds code 0, overflow 0 and data change 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_end_i | input | 1 | High in the cycle whose rising edge ends the sample phase |
| comp_i | input | 16 | Latched comparator decisions, bit 0 lowest threshold |
| data_off_i | input | 1 | 1 floats the code bits (when the chip is on) |
| chip_on_i | input | 1 | 0 floats every output |
| code_o | output | 4 | Binary code, high means true, bit 0 LSB |
| ovf_o | output | 1 | Over-range flag |
| dchg_o | output | 1 | Toggles on each new result |
| code_oe_o | output | 1 | Drive enable of the code bits |
| stat_oe_o | output | 1 | Drive enable of overflow and data change |

## Verification
A clean thermometer sweep of all 17 levels checks the count-to-code mapping and the single over-range point. Words with one cleared interior bit separate a ones counter from a highest-set-bit finder. Seeded random words, random capture strobes and random enable pairs show that nothing moves between strobes and that data change follows loads only. A walk through all four enable pairs confirms the split gating of the code group and the status group.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;
  localparam int unsigned CODE_W_DEF = 4;

  typedef struct packed {
    logic [CODE_W_DEF-1:0] code;
    logic                  ovf;
  } enc_result_t;
endpackage

// File: rtl/therm_ones_count.sv
module therm_ones_count #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned CNT_W = $clog2(IN_W + 1)
) (
  input  logic [IN_W-1:0]  therm_i,
  output logic [CNT_W-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < int'(IN_W); i++) begin
      count_o = count_o + CNT_W'(therm_i[i]);
    end
  end
endmodule

// File: rtl/code_saturate.sv
module code_saturate #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned CNT_W  = CODE_W + 1
) (
  input  logic [CNT_W-1:0]  count_i,
  output logic [CODE_W-1:0] code_o,
  output logic              ovf_o
);
  localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;

  always_comb begin
    ovf_o  = (count_i > CNT_W'(MAX_CODE));
    code_o = ovf_o ? {CODE_W{1'b1}} : count_i[CODE_W-1:0];
  end

  // R2: an over-range result must carry a saturated code
  always_comb begin
    if (ovf_o) begin
      assert_sat_code_R2: assert (code_o == {CODE_W{1'b1}});
    end
  end
endmodule

// File: rtl/result_reg.sv
module result_reg #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ovf_i,
  output logic [CODE_W-1:0] code_q_o,
  output logic              ovf_q_o,
  output logic              dchg_q_o
);
  logic [CODE_W-1:0] code_d;
  logic              ovf_d;
  logic              dchg_d;

  always_comb begin
    code_d = code_q_o;
    ovf_d  = ovf_q_o;
    dchg_d = dchg_q_o;
    if (load_i) begin
      code_d = code_i;
      ovf_d  = ovf_i;
      dchg_d = ~dchg_q_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q_o <= '0;
      ovf_q_o  <= 1'b0;
      dchg_q_o <= 1'b0;
    end else begin
      code_q_o <= code_d;
      ovf_q_o  <= ovf_d;
      dchg_q_o <= dchg_d;
    end
  end

  // R5: without a load the stored result does not move
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(code_q_o) && $stable(ovf_q_o) && $stable(dchg_q_o)));

  // R6: every load flips the change marker
  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (dchg_q_o != $past(dchg_q_o)));
endmodule

// File: rtl/out_enable_decode.sv
module out_enable_decode (
  input  logic data_off_i,
  input  logic chip_on_i,
  output logic code_oe_o,
  output logic stat_oe_o
);
  always_comb begin
    stat_oe_o = chip_on_i;
    code_oe_o = chip_on_i & ~data_off_i;
  end
endmodule

// File: rtl/flash_code_encoder.sv
module flash_code_encoder
  import flash_enc_pkg::*;
#(
  parameter int unsigned CODE_W = CODE_W_DEF,
  localparam int unsigned N_COMP = 1 << CODE_W,
  localparam int unsigned CNT_W  = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_end_i,
  input  logic [N_COMP-1:0] comp_i,
  input  logic              data_off_i,
  input  logic              chip_on_i,
  output logic [CODE_W-1:0] code_o,
  output logic              ovf_o,
  output logic              dchg_o,
  output logic              code_oe_o,
  output logic              stat_oe_o
);
  logic [CNT_W-1:0]  ones_cnt;
  logic [CODE_W-1:0] code_comb;
  logic              ovf_comb;
  logic [CODE_W-1:0] code_q;
  logic              ovf_q;
  logic              dchg_q;

  therm_ones_count #(.IN_W(N_COMP), .CNT_W(CNT_W)) u_count (
    .therm_i (comp_i),
    .count_o (ones_cnt)
  );

  code_saturate #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_sat (
    .count_i (ones_cnt),
    .code_o  (code_comb),
    .ovf_o   (ovf_comb)
  );

  result_reg #(.CODE_W(CODE_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (conv_end_i),
    .code_i   (code_comb),
    .ovf_i    (ovf_comb),
    .code_q_o (code_q),
    .ovf_q_o  (ovf_q),
    .dchg_q_o (dchg_q)
  );

  out_enable_decode u_oe (
    .data_off_i (data_off_i),
    .chip_on_i  (chip_on_i),
    .code_oe_o  (code_oe_o),
    .stat_oe_o  (stat_oe_o)
  );

  assign code_o = code_oe_o ? code_q : {CODE_W{1'bz}};
  assign ovf_o  = stat_oe_o ? ovf_q  : 1'bz;
  assign dchg_o = stat_oe_o ? dchg_q : 1'bz;

  // R3: capturing a word with any clear bit leaves no over-range flag
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end_i && !(&comp_i)) |=> !ovf_q);

  // R2: capturing a full word raises the flag
  assert_full_scale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end_i && (&comp_i)) |=> (ovf_q && (&code_q)));

  // R9: chip off floats both groups
  always_comb begin
    if (!chip_on_i) begin
      assert_all_float_R9: assert (!code_oe_o && !stat_oe_o);
    end
  end

  // R8: status stays driven whenever the code group is floated with chip on
  always_comb begin
    if (chip_on_i && data_off_i) begin
      assert_split_gate_R8: assert (stat_oe_o && !code_oe_o);
    end
  end
endmodule

// File: tb/flash_code_encoder_tb_top.sv
`timescale 1ns/1ps
module flash_code_encoder_tb_top;
  localparam int CW = 4;
  localparam int NC = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          conv_end;
  logic [NC-1:0] comp;
  logic          data_off;
  logic          chip_on;
  logic [CW-1:0] code;
  logic          ovf, dchg, code_oe, stat_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [CW-1:0] m_code;
  logic          m_ovf;
  logic          m_dchg;

  always #2.5 clk = ~clk;

  flash_code_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .conv_end_i(conv_end), .comp_i(comp),
    .data_off_i(data_off), .chip_on_i(chip_on), .code_o(code), .ovf_o(ovf),
    .dchg_o(dchg), .code_oe_o(code_oe), .stat_oe_o(stat_oe)
  );

  function automatic int ones(logic [NC-1:0] w);
    int n = 0;
    for (int i = 0; i < NC; i++) n += int'(w[i]);
    return n;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, clock edge, sample at next negedge
  task automatic cycle(logic [NC-1:0] w, logic ld, string req);
    comp = w;
    conv_end = ld;
    @(posedge clk);
    @(negedge clk);
    if (ld) begin
      int n = ones(w);
      m_ovf  = (n > NC - 1);
      m_code = m_ovf ? {CW{1'b1}} : CW'(n);
      m_dchg = ~m_dchg;
    end
    if (code_oe) chk(req, int'(code), int'(m_code));
    if (stat_oe) begin
      chk(req, int'(ovf), int'(m_ovf));
      chk("R6", int'(dchg), int'(m_dchg));
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; conv_end = 1'b0; comp = '1; data_off = 1'b0; chip_on = 1'b1;
    m_code = '0; m_ovf = 1'b0; m_dchg = 1'b0;
    repeat (3) @(negedge clk);
    conv_end = 1'b1;
    @(negedge clk);
    // R10: reset holds zeros even with a full word and a strobe present
    chk("R10", int'(code), 0);
    chk("R10", int'(ovf), 0);
    chk("R10", int'(dchg), 0);
    conv_end = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 / R3: thermometer sweep of all 17 levels
    for (int k = 0; k <= NC; k++) begin
      logic [NC:0] t;
      t = (17'd1 << k) - 17'd1;
      cycle(t[NC-1:0], 1'b1, (k == NC) ? "R2" : "R1");
      if (k < NC) chk("R3", int'(ovf), 0);
      else chk("R2", int'({ovf, code}), 31);
    end

    // R4: single bubble inside a thermometer word
    for (int k = 3; k <= NC; k++) begin
      logic [NC:0] t;
      t = (17'd1 << k) - 17'd1;
      t[k/2] = 1'b0;
      cycle(t[NC-1:0], 1'b1, "R4");
      chk("R4", int'(code), k - 1);
    end

    // R5: no strobe, changed input, nothing moves
    cycle(16'h00FF, 1'b1, "R1");
    cycle(16'hFFFF, 1'b0, "R5");
    chk("R5", int'(code), 8);
    chk("R5", int'(ovf), 0);

    // R7 / R8 / R9: every enable pair
    for (int e = 0; e < 4; e++) begin
      data_off = e[0];
      chip_on  = e[1];
      #1;
      chk(chip_on ? (data_off ? "R8" : "R7") : "R9", int'(code_oe), int'(chip_on && !data_off));
      chk(chip_on ? (data_off ? "R8" : "R7") : "R9", int'(stat_oe), int'(chip_on));
    end
    data_off = 1'b0; chip_on = 1'b1;

    // seeded random words, strobes and enables
    for (int i = 0; i < 300; i++) begin
      logic [NC-1:0] w;
      w = NC'($urandom);
      if (i % 7 == 0) w = '1;
      data_off = 1'($urandom);
      chip_on  = ($urandom % 4) != 0;
      cycle(w, 1'($urandom), "R5");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule